// File: doc/BRIEF.md
# ROM Read Path Sequencer with Self-Timed Capture

This block drives one read at a time through a mask-ROM bit-line array and returns a corrected, narrowed result. Between reads every bit line is held high. An accepted request first releases that hold, then raises exactly one word line. A programmed cell discharges its bit line to 0, and an unprogrammed cell leaves it at 1. Output latches follow the column-multiplexed bit lines while the word line is up. They freeze on the clock edge at which a dummy reference bit line, whose cells are all programmed, is seen low. Capture is therefore timed by a line that discharges like the slowest data line, not by a fixed count.

Each of the 71 latched bits comes from an eight-way column selector. The selector is built as three cascaded two-way stages, so 568 bit lines become 71 bits. Those bits form a single-error-correcting Hamming codeword over 64 data bits. After correction, a byte, halfword or word of the 64-bit result is returned on a 32-bit bus. The array itself sits outside the block: the block drives the word-line address and the hold control, and it reads back the bit lines and the reference line.

Top module: `rom_read_path`

## Requirements
- R1: While reset is low and after it is released, precharge_en is 1, wl_en is 0, rd_valid is 0 and rd_ready is 0. rd_ready first rises PRE_CYC (default 3) clock cycles after reset is released.
- R2: A request is taken when rd_req is high at a clock edge while rd_ready is high. In the cycle that follows, precharge_en is 0 and wl_en is 0. In the cycle after that, wl_en is 1 and wl_addr equals rd_addr[9:6]. precharge_en and wl_en are never high together.
- R3: While wl_en is high the latches follow the selected bit lines. They close at the first clock edge at which ref_bitline is sampled 0, holding the values present at that edge. Bit-line values that arrive only after that edge do not reach the result.
- R4: rd_valid is high for exactly one cycle. It rises at the clock edge after the one that closed the latches, so it appears 4 + D cycles after the request edge when ref_bitline falls D cycles after wl_en rises.
- R5: Latched bit k is taken from bitlines[k*8 + c], where c = rd_addr[5:3]. The selection is made in three 2:1 stages steered by rd_addr[3], then rd_addr[4], then rd_addr[5].
- R6: Latched bit k holds Hamming position k+1. Positions 1, 2, 4, 8, 16, 32 and 64 hold even-parity check bits. The remaining positions hold data bits 0 to 63 in ascending order, so data bit 0 is at position 3 and data bit 63 is at position 71.
- R7: A nonzero syndrome from 1 to 71 inverts that position before the data is extracted, and err_corrected is 1 with rd_valid.
- R8: A syndrome above 71 leaves the word unchanged and sets err_uncorrectable with rd_valid. The two error flags are never high together.
- R9: width_sel 0 returns data byte rd_addr[2:0]. width_sel 1 returns halfword rd_addr[2:1]. width_sel 2 or 3 returns word rd_addr[2]. Slice 0 is the least significant part of the data, and unused upper rd_data bits are 0.
- R10: After the latches close, precharge_en is 1 and wl_en is 0 for PRE_CYC cycles before rd_ready rises again. A request made while rd_ready is low causes no word-line activity and no rd_valid.
- R11: rd_data, err_corrected and err_uncorrectable change only in a cycle where rd_valid rises. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | 10 | Row [9:6], column [5:3], byte offset [2:0] |
| width_sel | input | 2 | Result width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| rd_ready | output | 1 | Block idle and precharged, request can be taken |
| precharge_en | output | 1 | Hold all bit lines high |
| wl_en | output | 1 | Word line raised |
| wl_addr | output | 4 | Row whose word line is raised |
| bitlines | input | 568 | Array bit lines, line k*8+c is bit k of column c |
| ref_bitline | input | 1 | Dummy reference line, discharges when the word line is up |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | 32 | Corrected and narrowed result |
| err_corrected | output | 1 | A single-bit error was repaired |
| err_uncorrectable | output | 1 | Syndrome pointed outside the codeword |

## Verification
The sharp case is the cycle in which the last data line settles and the reference line falls at the same edge. The latch must still take the settled value, even though it closes at that very edge. The bench provokes this by delaying its array model's data and reference timing by equal counts, and judges the returned word against its own encoded contents. It also delays the data by one cycle more than the reference. The word latched then is the all-ones precharge level, which decodes cleanly, and it must come back as all ones with no error flag.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    typedef enum logic [1:0] {
        SEQ_RESTORE = 2'd0,
        SEQ_IDLE    = 2'd1,
        SEQ_RELEASE = 2'd2,
        SEQ_SENSE   = 2'd3
    } seq_state_e;

    localparam logic [1:0] WSEL_BYTE = 2'd0;
    localparam logic [1:0] WSEL_HALF = 2'd1;

endpackage

// File: rtl/rrp_sequencer.sv
module rrp_sequencer #(
    parameter int ROW_W     = 4,
    parameter int COL_SEL_W = 3,
    parameter int OFS_W     = 3,
    parameter int PRE_CYC   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [ROW_W+COL_SEL_W+OFS_W-1:0] rd_addr,
    input  logic [1:0]           width_sel,
    input  logic                 ref_bitline,
    output logic                 rd_ready,
    output logic                 precharge_en,
    output logic                 wl_en,
    output logic [ROW_W-1:0]     wl_addr,
    output logic                 latch_en,
    output logic                 close_evt,
    output logic [COL_SEL_W-1:0] col_sel,
    output logic [OFS_W-1:0]     ofs,
    output logic [1:0]           wsel
);
    import rrp_pkg::*;

    localparam int CNT_W = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRE_CYC - 1);

    typedef struct packed {
        seq_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [ROW_W-1:0]     row;
        logic [COL_SEL_W-1:0] col;
        logic [OFS_W-1:0]     ofs;
        logic [1:0]           wsel;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_RESTORE: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_IDLE: begin
                if (rd_req) begin
                    seq_d.state = SEQ_RELEASE;
                    seq_d.ofs   = rd_addr[OFS_W-1:0];
                    seq_d.col   = rd_addr[OFS_W +: COL_SEL_W];
                    seq_d.row   = rd_addr[OFS_W+COL_SEL_W +: ROW_W];
                    seq_d.wsel  = width_sel;
                end
            end
            SEQ_RELEASE: begin
                seq_d.state = SEQ_SENSE;
            end
            SEQ_SENSE: begin
                if (!ref_bitline) begin
                    seq_d.state = SEQ_RESTORE;
                    seq_d.cnt   = '0;
                end
            end
            default: seq_d.state = SEQ_RESTORE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_RESTORE, cnt: '0, row: '0, col: '0, ofs: '0, wsel: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_ready     = (seq_q.state == SEQ_IDLE);
    assign precharge_en = (seq_q.state == SEQ_RESTORE) || (seq_q.state == SEQ_IDLE);
    assign wl_en        = (seq_q.state == SEQ_SENSE);
    assign latch_en     = (seq_q.state == SEQ_SENSE);
    assign close_evt    = (seq_q.state == SEQ_SENSE) && !ref_bitline;
    assign wl_addr      = seq_q.row;
    assign col_sel      = seq_q.col;
    assign ofs          = seq_q.ofs;
    assign wsel         = seq_q.wsel;

endmodule

// File: rtl/rrp_colmux.sv
module rrp_colmux #(
    parameter int CW        = 71,
    parameter int COL_SEL_W = 3
) (
    input  logic [CW*(1<<COL_SEL_W)-1:0] bitlines,
    input  logic [COL_SEL_W-1:0]         col_sel,
    output logic [CW-1:0]                word
);
    localparam int COLS = 1 << COL_SEL_W;

    for (genvar b = 0; b < CW; b++) begin : g_bit
        for (genvar s = 0; s <= COL_SEL_W; s++) begin : g_st
            logic [(COLS>>s)-1:0] v;
            if (s == 0) begin : g_leaf
                assign v = bitlines[b*COLS +: COLS];
            end else begin : g_pair
                for (genvar k = 0; k < (COLS >> s); k++) begin : g_mux
                    assign v[k] = col_sel[s-1] ? g_st[s-1].v[2*k+1] : g_st[s-1].v[2*k];
                end
            end
        end
        assign word[b] = g_st[COL_SEL_W].v[0];
    end

endmodule

// File: rtl/rrp_sec_decode.sv
module rrp_sec_decode #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 7
) (
    input  logic [DATA_W+CHK_W-1:0] code,
    output logic [DATA_W-1:0]       data,
    output logic                    corrected,
    output logic                    uncorrectable
);
    localparam int CW = DATA_W + CHK_W;

    logic [CHK_W-1:0] syn;
    logic [CW-1:0]    fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= CW; p++) begin
            if (code[p-1]) syn = syn ^ CHK_W'(p);
        end
    end

    always_comb begin
        fixed         = code;
        corrected     = 1'b0;
        uncorrectable = 1'b0;
        if (syn != '0) begin
            if (int'(syn) <= CW) begin
                fixed[int'(syn)-1] = ~code[int'(syn)-1];
                corrected          = 1'b1;
            end else begin
                uncorrectable = 1'b1;
            end
        end
    end

    always_comb begin
        int k;
        k    = 0;
        data = '0;
        for (int p = 1; p <= CW; p++) begin
            if (((p & (p - 1)) != 0) && (k < DATA_W)) begin
                data[k] = fixed[p-1];
                k       = k + 1;
            end
        end
    end

endmodule

// File: rtl/rrp_narrow.sv
module rrp_narrow #(
    parameter int DATA_W = 64,
    parameter int OUT_W  = 32,
    parameter int OFS_W  = 3
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        wsel,
    output logic [OUT_W-1:0]  slice
);
    import rrp_pkg::*;

    always_comb begin
        slice = '0;
        unique case (wsel)
            WSEL_BYTE: slice[7:0]  = word[int'(ofs)*8 +: 8];
            WSEL_HALF: slice[15:0] = word[int'(ofs[OFS_W-1:1])*16 +: 16];
            default:   slice[31:0] = word[int'(ofs[OFS_W-1:2])*32 +: 32];
        endcase
    end

endmodule

// File: rtl/rom_read_path.sv
module rom_read_path #(
    parameter int DATA_W    = 64,
    parameter int CHK_W     = 7,
    parameter int COL_SEL_W = 3,
    parameter int ROW_W     = 4,
    parameter int PRE_CYC   = 3,
    parameter int OUT_W     = 32,
    localparam int CW       = DATA_W + CHK_W,
    localparam int BL_W     = CW * (1 << COL_SEL_W),
    localparam int OFS_W    = $clog2(DATA_W / 8),
    localparam int ADDR_W   = ROW_W + COL_SEL_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        width_sel,
    output logic              rd_ready,
    output logic              precharge_en,
    output logic              wl_en,
    output logic [ROW_W-1:0]  wl_addr,
    input  logic [BL_W-1:0]   bitlines,
    input  logic              ref_bitline,
    output logic              rd_valid,
    output logic [OUT_W-1:0]  rd_data,
    output logic              err_corrected,
    output logic              err_uncorrectable
);
    typedef struct packed {
        logic [CW-1:0]    latch;
        logic             done;
        logic             valid;
        logic [OUT_W-1:0] data;
        logic             corr;
        logic             unc;
    } path_regs_t;

    path_regs_t path_d, path_q;

    logic                 latch_en;
    logic                 close_evt;
    logic [COL_SEL_W-1:0] col_sel;
    logic [OFS_W-1:0]     ofs;
    logic [1:0]           wsel;
    logic [CW-1:0]        mux_word;
    logic [DATA_W-1:0]    fixed_data;
    logic                 dec_corr;
    logic                 dec_unc;
    logic [OUT_W-1:0]     narrowed;

    rrp_sequencer #(
        .ROW_W    (ROW_W),
        .COL_SEL_W(COL_SEL_W),
        .OFS_W    (OFS_W),
        .PRE_CYC  (PRE_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .width_sel   (width_sel),
        .ref_bitline (ref_bitline),
        .rd_ready    (rd_ready),
        .precharge_en(precharge_en),
        .wl_en       (wl_en),
        .wl_addr     (wl_addr),
        .latch_en    (latch_en),
        .close_evt   (close_evt),
        .col_sel     (col_sel),
        .ofs         (ofs),
        .wsel        (wsel)
    );

    rrp_colmux #(
        .CW       (CW),
        .COL_SEL_W(COL_SEL_W)
    ) mux_i (
        .bitlines(bitlines),
        .col_sel (col_sel),
        .word    (mux_word)
    );

    rrp_sec_decode #(
        .DATA_W(DATA_W),
        .CHK_W (CHK_W)
    ) dec_i (
        .code         (path_q.latch),
        .data         (fixed_data),
        .corrected    (dec_corr),
        .uncorrectable(dec_unc)
    );

    rrp_narrow #(
        .DATA_W(DATA_W),
        .OUT_W (OUT_W),
        .OFS_W (OFS_W)
    ) nar_i (
        .word (fixed_data),
        .ofs  (ofs),
        .wsel (wsel),
        .slice(narrowed)
    );

    always_comb begin
        path_d       = path_q;
        path_d.valid = 1'b0;
        path_d.done  = close_evt;
        if (latch_en) begin
            path_d.latch = mux_word;
        end
        if (path_q.done) begin
            path_d.valid = 1'b1;
            path_d.data  = narrowed;
            path_d.corr  = dec_corr;
            path_d.unc   = dec_unc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= '0;
        end else begin
            path_q <= path_d;
        end
    end

    assign rd_valid          = path_q.valid;
    assign rd_data           = path_q.data;
    assign err_corrected     = path_q.corr;
    assign err_uncorrectable = path_q.unc;

endmodule

// File: rtl/rom_read_path_chk.sv
module rom_read_path_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_ready,
    input logic             precharge_en,
    input logic             wl_en,
    input logic             ref_bitline,
    input logic             rd_valid,
    input logic [OUT_W-1:0] rd_data,
    input logic             err_corrected,
    input logic             err_uncorrectable
);

    AST_NO_WL_DURING_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(precharge_en && wl_en)); // R2

    AST_WL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_en) |-> !$past(precharge_en)); // R2

    AST_WL_DROPS_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wl_en) |-> !$past(ref_bitline)); // R3

    AST_VALID_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($past(wl_en, 2) && !$past(ref_bitline, 2))); // R4

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corrected && err_uncorrectable)); // R8

    AST_READY_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (precharge_en && !wl_en)); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> ($stable(rd_data) && $stable(err_corrected) && $stable(err_uncorrectable))); // R11

endmodule

bind rom_read_path rom_read_path_chk #(.OUT_W(OUT_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .rd_ready         (rd_ready),
    .precharge_en     (precharge_en),
    .wl_en            (wl_en),
    .ref_bitline      (ref_bitline),
    .rd_valid         (rd_valid),
    .rd_data          (rd_data),
    .err_corrected    (err_corrected),
    .err_uncorrectable(err_uncorrectable)
);

// File: tb/rom_read_path_tb_top.sv
module rom_read_path_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 71;
    localparam int COLS       = 8;
    localparam int PRE_CYC    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic [1:0]  width_sel = '0;
    logic        rd_ready, precharge_en, wl_en, rd_valid;
    logic        err_corrected, err_uncorrectable;
    logic [3:0]  wl_addr;
    logic [CW*COLS-1:0] bitlines;
    logic        ref_bitline;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    int          ref_dly = 0;
    int          data_dly = 0;
    int          ref_cnt = 0;
    logic [2:0]  cur_col = '0;
    logic [CW-1:0] flip_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_read_path dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .rd_req           (rd_req),
        .rd_addr          (rd_addr),
        .width_sel        (width_sel),
        .rd_ready         (rd_ready),
        .precharge_en     (precharge_en),
        .wl_en            (wl_en),
        .wl_addr          (wl_addr),
        .bitlines         (bitlines),
        .ref_bitline      (ref_bitline),
        .rd_valid         (rd_valid),
        .rd_data          (rd_data),
        .err_corrected    (err_corrected),
        .err_uncorrectable(err_uncorrectable)
    );

    function automatic logic [63:0] cell_word(input logic [3:0] row, input logic [2:0] col);
        logic [31:0] idx;
        idx = {25'd0, row, col};
        return {32'h9E3779B9 * (idx + 32'd1), 32'h7F4A7C15 ^ (32'h01000193 * idx)};
    endfunction

    // R6: Hamming layout, check bits at powers of two, even parity
    function automatic logic [CW-1:0] encode(input logic [63:0] d);
        logic [CW-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) begin
                if (((p >> j) & 1) == 1 && p != (1 << j)) par = par ^ c[p-1];
            end
            c[(1 << j) - 1] = par;
        end
        return c;
    endfunction

    function automatic logic [31:0] pick(input logic [63:0] w, input logic [2:0] o, input logic [1:0] ws);
        case (ws)
            2'd0:    return {24'd0, w[o*8 +: 8]};
            2'd1:    return {16'd0, w[o[2:1]*16 +: 16]};
            default: return w[o[2]*32 +: 32];
        endcase
    endfunction

    // behavioural array: lines high unless the word line is up and the data has settled
    always_comb begin
        bitlines = '1;
        if (!precharge_en && wl_en && ref_cnt >= data_dly) begin
            for (int c = 0; c < COLS; c++) begin
                logic [CW-1:0] cw;
                cw = encode(cell_word(wl_addr, 3'(c)));
                if (3'(c) == cur_col) cw = cw ^ flip_mask;
                for (int k = 0; k < CW; k++) bitlines[k*COLS + c] = cw[k];
            end
        end
    end

    assign ref_bitline = !(wl_en && ref_cnt >= ref_dly);

    always @(posedge clk) begin
        if (!wl_en) ref_cnt <= 0;
        else        ref_cnt <= ref_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [9:0] addr;
        logic [1:0] wsel;
        logic [2:0] rdly;
        logic [2:0] ddly;
        logic [6:0] fa;
        logic [6:0] fb;
        logic       ecorr;
        logic       eunc;
        logic       eones;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{10'd0,    2'd0, 3'd0, 3'd0, 7'd0,  7'd0, 1'b0, 1'b0, 1'b0},
        '{10'd238,  2'd0, 3'd2, 3'd1, 7'd0,  7'd0, 1'b0, 1'b0, 1'b0},
        '{10'd466,  2'd1, 3'd1, 3'd0, 7'd0,  7'd0, 1'b0, 1'b0, 1'b0},
        '{10'd1020, 2'd2, 3'd3, 3'd3, 7'd0,  7'd0, 1'b0, 1'b0, 1'b0},
        '{10'd72,   2'd3, 3'd0, 3'd0, 7'd0,  7'd0, 1'b0, 1'b0, 1'b0},
        '{10'd160,  2'd0, 3'd0, 3'd0, 7'd3,  7'd0, 1'b1, 1'b0, 1'b0},
        '{10'd160,  2'd2, 3'd1, 3'd0, 7'd1,  7'd0, 1'b1, 1'b0, 1'b0},
        '{10'd375,  2'd0, 3'd0, 3'd0, 7'd71, 7'd0, 1'b1, 1'b0, 1'b0},
        '{10'd375,  2'd2, 3'd0, 3'd0, 7'd64, 7'd8, 1'b0, 1'b1, 1'b0},
        '{10'd466,  2'd2, 3'd1, 3'd2, 7'd0,  7'd0, 1'b0, 1'b0, 1'b1},
        '{10'd238,  2'd1, 3'd4, 3'd4, 7'd40, 7'd0, 1'b1, 1'b0, 1'b0}
    };

    logic [31:0] last_data;

    task automatic do_read(input vec_t v);
        int lat;
        int guard;
        logic [63:0] w;
        logic [31:0] exp;
        logic [3:0] seen_row;
        guard = 0;
        while (!rd_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        ref_dly   = int'(v.rdly);
        data_dly  = int'(v.ddly);
        cur_col   = v.addr[5:3];
        flip_mask = '0;
        if (v.fa != 0) flip_mask[v.fa - 1] = 1'b1;
        if (v.fb != 0) flip_mask[v.fb - 1] = 1'b1;
        rd_addr   = v.addr;
        width_sel = v.wsel;
        rd_req    = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        chk(!precharge_en && !wl_en, "R2 release before word line", {30'd0, precharge_en, wl_en}, 32'd0);
        @(negedge clk);
        lat = 2;
        seen_row = wl_addr;
        chk(wl_en && !precharge_en && seen_row == v.addr[9:6], "R2 word line row",
            {27'd0, wl_en, seen_row}, {27'd1, v.addr[9:6]});
        while (!rd_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 4 + int'(v.rdly), "R4 valid latency", 32'(lat), 32'(4 + int'(v.rdly)));
        w = v.eones ? 64'hFFFF_FFFF_FFFF_FFFF : cell_word(v.addr[9:6], v.addr[5:3]);
        exp = pick(w, v.addr[2:0], v.wsel);
        if (!v.eunc) begin
            chk(rd_data == exp, v.eones ? "R3 late data ignored" : "R5 R6 R7 R9 data", rd_data, exp);
        end
        chk(err_corrected == v.ecorr, "R7 corrected flag", {31'd0, err_corrected}, {31'd0, v.ecorr});
        chk(err_uncorrectable == v.eunc, "R8 uncorrectable flag", {31'd0, err_uncorrectable}, {31'd0, v.eunc});
        last_data = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(precharge_en && !wl_en && !rd_valid && !rd_ready, "R1 in reset",
            {28'd0, precharge_en, wl_en, rd_valid, rd_ready}, 32'h8);
        rst_n = 1'b1;
        for (int i = 1; i <= PRE_CYC; i++) begin
            @(negedge clk);
            chk(rd_ready == (i == PRE_CYC), "R1 ready after restore", {31'd0, rd_ready}, {31'd0, i == PRE_CYC});
            chk(precharge_en && !wl_en, "R1 precharged after reset", {30'd0, precharge_en, wl_en}, 32'h2);
        end

        for (int n = 0; n < NVEC; n++) do_read(VECS[n]);

        // R10: request while restoring is ignored; restore lasts PRE_CYC cycles
        do_read(VECS[0]);
        rd_addr = 10'd1020;
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(precharge_en && !wl_en && !rd_ready, "R10 restore cycle 2", {29'd0, precharge_en, wl_en, rd_ready}, 32'h4);
        @(negedge clk);
        chk(rd_ready, "R10 ready after restore", {31'd0, rd_ready}, 32'd1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!wl_en && !rd_valid, "R10 busy request ignored", {30'd0, wl_en, rd_valid}, 32'd0);
        end
        // R11 result held without a new strobe
        chk(rd_data == last_data, "R11 result held", rd_data, last_data);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule